// File: doc/BRIEF.md
# Interrupt Pending Eligibility Unit

This unit keeps the per-interrupt state for one bank of interrupts (32 by default) and produces a registered mask of the interrupts that may be offered to a processor interface. For each interrupt it stores a pending latch, a trigger mode, a registered copy of the input line, an enable bit, an active bit, a group bit and a group modifier. A small control word switches the three interrupt groups on or off and can force every group modifier to zero.

An interrupt is pending when its latch is set, or when it is level-sensitive and its input is high. It is eligible when it is pending, enabled, not active, and its group class is switched on. Software changes the per-bit arrays through one write port that carries an operation code and a data word. Each data bit acts on the interrupt with the same index. Priority selection, processor targeting and bus decoding sit outside this block.

Top module: `irq_elig_unit`

## Requirements
- R1: Reset clears every state array, the registered input copy, the control word and the eligibility mask. Enabling all interrupts and all groups after reset still gives an all-zero mask.
- R2: A trigger bit of 0 means level-sensitive. Such an interrupt counts as pending while its registered input is high, and stops counting once the input falls, unless its latch is set.
- R3: A trigger bit of 1 means edge-triggered. A 0-to-1 change of the input, seen against its registered copy, sets the pending latch, and the latch stays set after the input falls. If the same cycle carries a pending clear for that bit, the edge wins. Level-sensitive inputs never set the latch.
- R4: A pending interrupt is eligible only while its enable bit is 1 and its active bit is 0.
- R5: While control bit 3 (security disable) is 1, every group modifier is treated as 0.
- R6: The group mask passes an interrupt under any of three conditions. Control bit 1 is set and the group bit is 1. Control bit 2 is set and the group bit is 0 with modifier 1. Control bit 0 is set and both the group bit and the modifier are 0. When none of these holds, the interrupt is masked.
- R7: When wr_en is high, wr_op selects the action on the bits that are set in wr_data. 0 sets pending bits, 1 clears pending bits, 2 sets enable bits, 3 clears enable bits, 4 sets active bits, 5 clears active bits. 6, 7 and 8 load the whole trigger, group and modifier words from wr_data. Codes 9 to 15 change nothing. A write takes effect at the clock edge where it is sampled.
- R8: elig_mask is a register. It reflects state one edge after that state changes, so a write or input change sampled at edge k shows on the output after edge k+1.
- R9: ctrl_data is loaded into the control word at an edge where ctrl_we is high. The bits are: 0 enables group 0, 1 enables non-secure group 1, 2 enables secure group 1, 3 is security disable.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Raw interrupt input lines |
| wr_en | input | 1 | State write strobe |
| wr_op | input | 4 | State write operation code |
| wr_data | input | NUM_IRQ | Per-interrupt write data |
| ctrl_we | input | 1 | Control word load strobe |
| ctrl_data | input | 4 | New control word |
| elig_mask | output | NUM_IRQ | Registered eligibility mask |

## Verification
A write, a control load or an edge on an input is stored at the first edge that samples it, and the mask follows at the next edge. The bench therefore drives on the falling edge and samples after two rising edges. It also checks once after a single rising edge to confirm that the mask has not yet moved. A level input takes the same two edges, because the registered input copy sets the level term. Each sweep step finishes all writes and lets the inputs settle before it loads each of the 16 control values, and it checks each value one full cycle after the load.

// File: rtl/irq_elig_pkg.sv
package irq_elig_pkg;

  localparam int unsigned OP_W   = 4;
  localparam int unsigned CTRL_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_PEND_SET  = 4'd0,
    OP_PEND_CLR  = 4'd1,
    OP_EN_SET    = 4'd2,
    OP_EN_CLR    = 4'd3,
    OP_ACT_SET   = 4'd4,
    OP_ACT_CLR   = 4'd5,
    OP_TRIG_LOAD = 4'd6,
    OP_GRP_LOAD  = 4'd7,
    OP_MOD_LOAD  = 4'd8
  } wr_op_e;

  // bit 3 security disable, bit 2 secure g1, bit 1 non-secure g1, bit 0 g0
  typedef struct packed {
    logic sec_dis;
    logic en_g1s;
    logic en_g1ns;
    logic en_g0;
  } ctrl_t;

  // indices of the plain per-bit state fields
  localparam int unsigned F_EN       = 0;
  localparam int unsigned F_ACT      = 1;
  localparam int unsigned F_TRIG     = 2;
  localparam int unsigned F_GRP      = 3;
  localparam int unsigned F_MOD      = 4;
  localparam int unsigned NUM_FIELDS = 5;

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_elig_pkg::*;
(
  input  logic                  wr_en,
  input  logic [OP_W-1:0]       wr_op,
  output logic                  pend_set,
  output logic                  pend_clr,
  output logic [NUM_FIELDS-1:0] set_stb,
  output logic [NUM_FIELDS-1:0] clr_stb,
  output logic [NUM_FIELDS-1:0] load_stb
);

  always_comb begin
    pend_set = 1'b0;
    pend_clr = 1'b0;
    set_stb  = '0;
    clr_stb  = '0;
    load_stb = '0;
    if (wr_en) begin
      case (wr_op)
        OP_PEND_SET:  pend_set         = 1'b1;
        OP_PEND_CLR:  pend_clr         = 1'b1;
        OP_EN_SET:    set_stb[F_EN]    = 1'b1;
        OP_EN_CLR:    clr_stb[F_EN]    = 1'b1;
        OP_ACT_SET:   set_stb[F_ACT]   = 1'b1;
        OP_ACT_CLR:   clr_stb[F_ACT]   = 1'b1;
        OP_TRIG_LOAD: load_stb[F_TRIG] = 1'b1;
        OP_GRP_LOAD:  load_stb[F_GRP]  = 1'b1;
        OP_MOD_LOAD:  load_stb[F_MOD]  = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/irq_bitreg.sv
module irq_bitreg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic             load_stb,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r, q_nxt;
  logic             upd;

  assign upd = set_stb | clr_stb | load_stb;

  always_comb begin
    q_nxt = q_r;
    if (load_stb)     q_nxt = data;
    else if (set_stb) q_nxt = q_r | data;
    else if (clr_stb) q_nxt = q_r & ~data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_nxt;
  end

  assign q = q_r;

  // R7: a load leaves exactly the written word
  a_r7_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> (q_r == $past(data)));
  // R7: cleared bits read zero afterwards
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !load_stb && !set_stb) |=> ((q_r & $past(data)) == '0));
  // R7: without a strobe the word holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(q_r));

endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] irq_in,
  input  logic [WIDTH-1:0] trig_edge,
  input  logic [WIDTH-1:0] sw_set,
  input  logic [WIDTH-1:0] sw_clr,
  output logic [WIDTH-1:0] in_q,
  output logic [WIDTH-1:0] latch
);

  logic [WIDTH-1:0] in_r, latch_r, latch_nxt, rise;
  logic             latch_upd;

  assign rise      = irq_in & ~in_r & trig_edge;
  // edge detection outranks a software clear in the same cycle
  assign latch_nxt = (latch_r & ~sw_clr) | sw_set | rise;
  assign latch_upd = (|sw_set) | (|sw_clr) | (|rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_r <= '0;
    else        in_r <= irq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latch_r <= '0;
    else if (latch_upd) latch_r <= latch_nxt;
  end

  assign in_q  = in_r;
  assign latch = latch_r;

  // R3: a rising edge on an edge-mode line leaves its latch set
  a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((latch_r & $past(rise)) == $past(rise)));
  // R3: level-mode lines never raise the latch by themselves
  a_r3_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_r & ~$past(latch_r) & ~$past(trig_edge) & ~$past(sw_set)) == '0));

endmodule

// File: rtl/irq_group_gate.sv
module irq_group_gate
  import irq_elig_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  ctrl_t            ctrl,
  input  logic [WIDTH-1:0] grp,
  input  logic [WIDTH-1:0] modif,
  output logic [WIDTH-1:0] gmask
);

  logic [WIDTH-1:0] mod_eff;

  always_comb begin
    mod_eff = ctrl.sec_dis ? '0 : modif;
    gmask   = '0;
    if (ctrl.en_g1ns) gmask = gmask | grp;
    if (ctrl.en_g1s)  gmask = gmask | (~grp & mod_eff);
    if (ctrl.en_g0)   gmask = gmask | (~grp & ~mod_eff);
  end

endmodule

// File: rtl/irq_elig_unit.sv
module irq_elig_unit
  import irq_elig_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               wr_en,
  input  logic [3:0]         wr_op,
  input  logic [NUM_IRQ-1:0] wr_data,
  input  logic               ctrl_we,
  input  logic [3:0]         ctrl_data,
  output logic [NUM_IRQ-1:0] elig_mask
);

  logic                               pend_set, pend_clr;
  logic [NUM_FIELDS-1:0]              set_stb, clr_stb, load_stb;
  logic [NUM_FIELDS-1:0][NUM_IRQ-1:0] fld_q;
  logic [NUM_IRQ-1:0] en_v, act_v, trig_v, grp_v, mod_v;
  logic [NUM_IRQ-1:0] in_q, latch_v, pend_v, gmask, elig_nxt, elig_q;
  ctrl_t              ctrl_q, ctrl_nxt;

  irq_wr_decode u_dec (
    .wr_en    (wr_en),
    .wr_op    (wr_op),
    .pend_set (pend_set),
    .pend_clr (pend_clr),
    .set_stb  (set_stb),
    .clr_stb  (clr_stb),
    .load_stb (load_stb)
  );

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    irq_bitreg #(.WIDTH(NUM_IRQ)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_stb  (set_stb[k]),
      .clr_stb  (clr_stb[k]),
      .load_stb (load_stb[k]),
      .data     (wr_data),
      .q        (fld_q[k])
    );
  end

  assign en_v   = fld_q[F_EN];
  assign act_v  = fld_q[F_ACT];
  assign trig_v = fld_q[F_TRIG];
  assign grp_v  = fld_q[F_GRP];
  assign mod_v  = fld_q[F_MOD];

  irq_pend_latch #(.WIDTH(NUM_IRQ)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .trig_edge (trig_v),
    .sw_set    (pend_set ? wr_data : '0),
    .sw_clr    (pend_clr ? wr_data : '0),
    .in_q      (in_q),
    .latch     (latch_v)
  );

  irq_group_gate #(.WIDTH(NUM_IRQ)) u_gate (
    .ctrl  (ctrl_q),
    .grp   (grp_v),
    .modif (mod_v),
    .gmask (gmask)
  );

  // control word next state and register
  assign ctrl_nxt = ctrl_we ? ctrl_t'(ctrl_data) : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_nxt;
  end

  // eligibility next state and register
  assign pend_v   = latch_v | (~trig_v & in_q);
  assign elig_nxt = pend_v & en_v & ~act_v & gmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elig_q <= '0;
    else        elig_q <= elig_nxt;
  end

  assign elig_mask = elig_q;

  // R4: nothing active in the previous cycle is offered now
  a_r4_active_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((elig_q & $past(act_v)) == '0));
  // R4: nothing disabled in the previous cycle is offered now
  a_r4_disabled_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((elig_q & ~$past(en_v)) == '0));
  // R6: with all groups off the mask empties
  a_r6_all_groups_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en_g0 && !ctrl_q.en_g1s && !ctrl_q.en_g1ns) |=> (elig_q == '0));
  // R5: security disable leaves group-0 bits reachable only via bit 0
  a_r5_secdis_collapse: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.sec_dis && !ctrl_q.en_g0) |=> ((elig_q & ~$past(grp_v)) == '0));
  // R9: a load leaves the control word equal to the data
  a_r9_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q == $past(ctrl_data)));

endmodule

// File: tb/irq_elig_unit_test.sv
module irq_elig_unit_test;

  localparam int N = 32;
  localparam logic [3:0] PSET = 4'd0, PCLR = 4'd1, ESET = 4'd2, ECLR = 4'd3,
                         ASET = 4'd4, ACLR = 4'd5, TLD = 4'd6, GLD = 4'd7, MLD = 4'd8;

  logic         clk, rst_n, wr_en, ctrl_we;
  logic [N-1:0] irq_in, wr_data, elig_mask;
  logic [3:0]   wr_op, ctrl_data;
  int           n_chk, n_fail;
  bit           done;

  irq_elig_unit #(.NUM_IRQ(N)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_op(wr_op),
    .wr_data(wr_data), .ctrl_we(ctrl_we), .ctrl_data(ctrl_data), .elig_mask(elig_mask)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] op, input logic [N-1:0] d);
    wr_en = 1'b1; wr_op = op; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wctrl(input logic [3:0] c);
    ctrl_we = 1'b1; ctrl_data = c;
    tick();
    ctrl_we = 1'b0;
  endtask

  function automatic logic [N-1:0] model(
      input logic [N-1:0] pp, lv, tr, en, ac, gr, md, input logic [3:0] c);
    logic [N-1:0] pend, mdf, gm;
    pend = pp | (~tr & lv);
    mdf  = c[3] ? '0 : md;
    gm   = '0;
    if (c[1]) gm |= gr;
    if (c[2]) gm |= ~gr & mdf;
    if (c[0]) gm |= ~gr & ~mdf;
    return pend & en & ~ac & gm;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; ctrl_we = 1'b0;
    irq_in = '0; wr_data = '0; wr_op = '0; ctrl_data = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset mask", elig_mask, '0);
    // R1: all groups and enables on, yet nothing pending after reset
    wctrl(4'b0111);
    wr(ESET, '1);
    tick();
    chk("R1 cleared state", elig_mask, '0);

    // R3: edge mode latches a pulse; group 1 non-secure path
    wr(TLD, '1);
    wr(GLD, '1);
    wctrl(4'b0010);
    irq_in = 32'h0000_00F0;
    tick();
    irq_in = '0;
    tick();
    chk("R3 edge latched", elig_mask, 32'h0000_00F0);
    wr(PCLR, 32'h0000_0030);
    tick();
    chk("R7 pending clear", elig_mask, 32'h0000_00C0);

    // R8: one edge after the input the mask has not moved yet
    irq_in = 32'h1;
    tick();
    chk("R8 not yet", elig_mask, 32'h0000_00C0);
    irq_in = '0;
    tick();
    chk("R8 after two edges", elig_mask, 32'h0000_00C1);

    // R3: edge and pending clear in the same cycle, edge wins
    irq_in = 32'h2;
    wr_en = 1'b1; wr_op = PCLR; wr_data = 32'h2;
    tick();
    wr_en = 1'b0; wr_data = '0; irq_in = '0;
    tick();
    chk("R3 edge beats clear", elig_mask, 32'h0000_00C3);

    // R2: level mode follows the input
    wr(TLD, '0);
    wr(PCLR, '1);
    irq_in = 32'h0000_0100;
    tick(); tick();
    chk("R2 level high", elig_mask, 32'h0000_0100);
    irq_in = '0;
    tick(); tick();
    chk("R2 R3 level falls, no latch", elig_mask, '0);

    // R7: unused codes do nothing
    wr(PSET, 32'h5);
    tick();
    chk("R7 pending set", elig_mask, 32'h5);
    wr(4'hF, '1);
    wr(4'h9, '1);
    tick();
    chk("R7 unused codes", elig_mask, 32'h5);
    // R4: enable and active gating
    wr(ECLR, 32'h1);
    tick();
    chk("R4 disable", elig_mask, 32'h4);
    wr(ASET, 32'h4);
    tick();
    chk("R4 active", elig_mask, '0);
    wr(ACLR, 32'h4);
    tick();
    chk("R4 active cleared", elig_mask, 32'h4);

    // Sweep: 128 attribute combinations against all 16 control words
    for (int r = 0; r < 4; r++) begin
      logic [N-1:0] pp, lv, tr, en, ac, gr, md;
      for (int b = 0; b < N; b++) begin
        logic [6:0] c;
        c = 7'(r * N + b);
        pp[b] = c[0]; lv[b] = c[1]; tr[b] = c[2]; en[b] = c[3];
        ac[b] = c[4]; gr[b] = c[5]; md[b] = c[6];
      end
      wr(TLD, tr);
      wr(GLD, gr);
      wr(MLD, md);
      wr(ECLR, '1);
      wr(ESET, en);
      wr(ACLR, '1);
      wr(ASET, ac);
      irq_in = lv;
      tick(); tick();
      wr(PCLR, '1);
      wr(PSET, pp);
      for (int c = 0; c < 16; c++) begin
        wctrl(4'(c));
        tick();
        chk(c[3] ? "R5+R9 sweep" : "R6+R9 sweep", elig_mask,
            model(pp, lv, tr, en, ac, gr, md, 4'(c)));
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule